// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-power SDRAM interface. After a synchronous reset it drives the memory's command, bank and address pins through the full power-on procedure. First it waits a programmable stabilisation time with the bus held at NOP. It then closes every bank and performs two refresh cycles. Last, it writes the standard mode register and then the extended mode register. Each command is spaced from the next by its own minimum interval, and each interval is a clock-count parameter.

The two register values arrive on input ports and are presented on the address pins during the cycle of their load command. Reserved high bits are forced to zero on the way out. When the interval after the final load has expired, a ready flag rises and stays high, and the bus idles at NOP so that normal traffic can take it over. CKE is driven high throughout.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is sampled high, `ready` is low on the next cycle, the pins show NOP, and `cke` is high at all times.
- R2: Cycle 0 is the first clock period after reset is released. In cycles 0 to PWRUP_CYCLES-1 the command is NOP, encoded {cs_n,ras_n,cas_n,we_n}=0111, with `ba` and `addr` zero.
- R3: In cycle PWRUP_CYCLES the block issues a precharge of all banks. This is encoded 0010, with `addr` bit 10 high, all other address bits zero, and `ba`=0.
- R4: Exactly two refresh commands, encoded 0001 with `ba` and `addr` zero, are issued. The first comes T_RP cycles after the precharge and the second T_RC cycles after the first.
- R5: T_RC cycles after the second refresh, the standard mode register is loaded. This is encoded 0000 with `ba`=00 and `addr` equal to `mr_value` with bits 11:10 cleared.
- R6: T_MRD cycles after the standard load, the extended register is loaded. This is encoded 0000 with `ba`=10 and `addr` equal to `emr_value` with bits 11:8 cleared.
- R7: `ready` rises T_MRD cycles after the extended load. It then stays high with the pins at NOP until reset.
- R8: Every cycle that is not one of the five command slots above is NOP with `ba` and `addr` zero. No other command encoding ever appears.
- R9: A reset asserted partway through the sequence abandons it, and the next release restarts the full sequence from cycle 0.
- R10: Intervals of one cycle, including PWRUP_CYCLES=1, place the commands in back-to-back cycles with no NOP between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mr_value | input | ADDR_W | Value for the standard mode register |
| emr_value | input | ADDR_W | Value for the extended mode register |
| cke | output | 1 | Clock enable to the memory, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank / register select |
| addr | output | ADDR_W | Address / register value |
| ready | output | 1 | Initialization complete |

## Verification
The bench builds two copies side by side. The first has PWRUP_CYCLES=6, T_RP=3, T_RC=4 and T_MRD=2, so every wait state is entered with a different count and each spacing can be told apart from the others. The second sets every interval to 1, which removes all wait states and exercises the direct command-to-command transitions of R10. Both copies share one reset, so a reset pulse placed partway through a sequence hits them at different points of their sequences.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF1,
        ST_WAIT_RC1,
        ST_REF2,
        ST_WAIT_RC2,
        ST_LMR,
        ST_WAIT_MRD1,
        ST_LEMR,
        ST_WAIT_MRD2,
        ST_READY
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_PRE_ALL,
        OP_REFRESH,
        OP_LOAD_MR,
        OP_LOAD_EMR
    } op_e;

    // Order: cs_n, ras_n, cas_n, we_n
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_pins_t PINS_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_pwrup_field_mask.sv
module sdram_pwrup_field_mask #(
    parameter int ADDR_W = 12,
    parameter int KEEP   = 10
) (
    input  logic [ADDR_W-1:0] raw,
    output logic [ADDR_W-1:0] clean
);
    // Bits at and above KEEP are reserved and must reach the memory as zero.
    localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((64'd1 << KEEP) - 64'd1);

    assign clean = raw & KEEP_MASK;
endmodule

// File: rtl/sdram_pwrup_cmd_enc.sv
module sdram_pwrup_cmd_enc
    import sdram_pwrup_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] mr_clean,
    input  logic [ADDR_W-1:0] emr_clean,
    output cmd_pins_t         pins,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    // The extended register is selected with the upper bank bit set.
    localparam logic [BA_W-1:0] BA_EXT = BA_W'(2);

    always_comb begin
        pins = PINS_NOP;
        ba   = '0;
        addr = '0;
        unique case (op)
            OP_PRE_ALL: begin
                pins         = PINS_PRE;
                addr[AP_BIT] = 1'b1;
            end
            OP_REFRESH: begin
                pins = PINS_REF;
            end
            OP_LOAD_MR: begin
                pins = PINS_LMR;
                addr = mr_clean;
            end
            OP_LOAD_EMR: begin
                pins = PINS_LMR;
                addr = emr_clean;
                ba   = BA_EXT;
            end
            default: begin
                pins = PINS_NOP;
            end
        endcase
    end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter int PWRUP_CYCLES = 10000,
    parameter int T_RP         = 2,
    parameter int T_RC         = 7,
    parameter int T_MRD        = 2,
    parameter int ADDR_W       = 12,
    parameter int BA_W         = 2,
    parameter int AP_BIT       = 10,
    parameter int MR_KEEP      = 10,
    parameter int EMR_KEEP     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mr_value,
    input  logic [ADDR_W-1:0] emr_value,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    localparam int MAX_T1 = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int MAX_T2 = (MAX_T1 > T_MRD) ? MAX_T1 : T_MRD;
    localparam int MAX_T  = (MAX_T2 > PWRUP_CYCLES) ? MAX_T2 : PWRUP_CYCLES;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    // A wait state lasts T-1 cycles, so it is loaded with T-2 and left at zero.
    localparam logic [CNT_W-1:0] PWR_LOAD = CNT_W'(PWRUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'((T_RP  >= 2) ? T_RP  - 2 : 0);
    localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'((T_RC  >= 2) ? T_RC  - 2 : 0);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'((T_MRD >= 2) ? T_MRD - 2 : 0);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    localparam seq_regs_t REGS_RESET = '{state: ST_PWRUP, cnt: PWR_LOAD};

    seq_regs_t regs_d, regs_q;
    op_e       op;

    // Next-state logic
    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_PWRUP: begin
                if (regs_q.cnt == '0) regs_d.state = ST_PRE;
                else                  regs_d.cnt   = regs_q.cnt - 1'b1;
            end
            ST_PRE: begin
                regs_d.cnt   = RP_LOAD;
                regs_d.state = (T_RP > 1) ? ST_WAIT_RP : ST_REF1;
            end
            ST_WAIT_RP: begin
                if (regs_q.cnt == '0) regs_d.state = ST_REF1;
                else                  regs_d.cnt   = regs_q.cnt - 1'b1;
            end
            ST_REF1: begin
                regs_d.cnt   = RC_LOAD;
                regs_d.state = (T_RC > 1) ? ST_WAIT_RC1 : ST_REF2;
            end
            ST_WAIT_RC1: begin
                if (regs_q.cnt == '0) regs_d.state = ST_REF2;
                else                  regs_d.cnt   = regs_q.cnt - 1'b1;
            end
            ST_REF2: begin
                regs_d.cnt   = RC_LOAD;
                regs_d.state = (T_RC > 1) ? ST_WAIT_RC2 : ST_LMR;
            end
            ST_WAIT_RC2: begin
                if (regs_q.cnt == '0) regs_d.state = ST_LMR;
                else                  regs_d.cnt   = regs_q.cnt - 1'b1;
            end
            ST_LMR: begin
                regs_d.cnt   = MRD_LOAD;
                regs_d.state = (T_MRD > 1) ? ST_WAIT_MRD1 : ST_LEMR;
            end
            ST_WAIT_MRD1: begin
                if (regs_q.cnt == '0) regs_d.state = ST_LEMR;
                else                  regs_d.cnt   = regs_q.cnt - 1'b1;
            end
            ST_LEMR: begin
                regs_d.cnt   = MRD_LOAD;
                regs_d.state = (T_MRD > 1) ? ST_WAIT_MRD2 : ST_READY;
            end
            ST_WAIT_MRD2: begin
                if (regs_q.cnt == '0) regs_d.state = ST_READY;
                else                  regs_d.cnt   = regs_q.cnt - 1'b1;
            end
            ST_READY: begin
                regs_d = regs_q;
            end
            default: begin
                regs_d = REGS_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= REGS_RESET;
        else     regs_q <= regs_d;
    end

    // Command selected by the current state
    always_comb begin
        unique case (regs_q.state)
            ST_PRE:  op = OP_PRE_ALL;
            ST_REF1: op = OP_REFRESH;
            ST_REF2: op = OP_REFRESH;
            ST_LMR:  op = OP_LOAD_MR;
            ST_LEMR: op = OP_LOAD_EMR;
            default: op = OP_NOP;
        endcase
    end

    logic [ADDR_W-1:0] mr_clean, emr_clean;
    cmd_pins_t         pins;

    sdram_pwrup_field_mask #(.ADDR_W(ADDR_W), .KEEP(MR_KEEP)) i_mr_mask (
        .raw   (mr_value),
        .clean (mr_clean)
    );

    sdram_pwrup_field_mask #(.ADDR_W(ADDR_W), .KEEP(EMR_KEEP)) i_emr_mask (
        .raw   (emr_value),
        .clean (emr_clean)
    );

    sdram_pwrup_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) i_enc (
        .op        (op),
        .mr_clean  (mr_clean),
        .emr_clean (emr_clean),
        .pins      (pins),
        .ba        (ba),
        .addr      (addr)
    );

    assign cke   = 1'b1;
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign ready = (regs_q.state == ST_READY);

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int ADDR_W   = 12,
    parameter int BA_W     = 2,
    parameter int AP_BIT   = 10,
    parameter int MR_KEEP  = 10,
    parameter int EMR_KEEP = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              ready
);
    logic [3:0] pins;
    logic       is_nop, is_pre, is_ref, is_lmr;
    logic [1:0] ref_seen;

    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_lmr = (pins == 4'b0000);

    always_ff @(posedge clk) begin
        if (rst)                           ref_seen <= '0;
        else if (is_ref && ref_seen != 2'd3) ref_seen <= ref_seen + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !ready); // R1
    AST_CKE_DURING_RUN: assert property (@(posedge clk) disable iff (rst) cke && $stable(cke)); // R1
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst) is_pre |-> addr[AP_BIT]); // R3
    AST_LOAD_AFTER_TWO_REF: assert property (@(posedge clk) disable iff (rst) is_lmr |-> ref_seen == 2'd2); // R4
    AST_MR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (is_lmr && ba == BA_W'(0)) |-> ((addr >> MR_KEEP) == '0)); // R5
    AST_EMR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (is_lmr && ba == BA_W'(2)) |-> ((addr >> EMR_KEEP) == '0)); // R6
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst) ready |=> ready); // R7
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst) ready |-> is_nop); // R7
    AST_KNOWN_CMDS: assert property (@(posedge clk) disable iff (rst)
        is_nop || is_pre || is_ref || is_lmr); // R8
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .AP_BIT   (AP_BIT),
    .MR_KEEP  (MR_KEEP),
    .EMR_KEEP (EMR_KEEP)
) i_chk (
    .clk   (clk),
    .rst   (rst),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr),
    .ready (ready)
);

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;

    localparam int A_P = 6, A_RP = 3, A_RC = 4, A_MRD = 2;
    localparam int B_P = 1, B_RP = 1, B_RC = 1, B_MRD = 1;
    localparam int A_END = A_P + A_RP + 2 * A_RC + 2 * A_MRD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mr_value = '0;
    logic [11:0] emr_value = '0;

    logic        a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ready;
    logic [1:0]  a_ba;
    logic [11:0] a_addr;
    logic        b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_ready;
    logic [1:0]  b_ba;
    logic [11:0] b_addr;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    sdram_pwrup_seq #(.PWRUP_CYCLES(A_P), .T_RP(A_RP), .T_RC(A_RC), .T_MRD(A_MRD)) i_sdram_pwrup_seq (
        .clk(clk), .rst(rst), .mr_value(mr_value), .emr_value(emr_value),
        .cke(a_cke), .cs_n(a_cs_n), .ras_n(a_ras_n), .cas_n(a_cas_n), .we_n(a_we_n),
        .ba(a_ba), .addr(a_addr), .ready(a_ready)
    );

    sdram_pwrup_seq #(.PWRUP_CYCLES(B_P), .T_RP(B_RP), .T_RC(B_RC), .T_MRD(B_MRD)) i_sdram_pwrup_seq_min (
        .clk(clk), .rst(rst), .mr_value(mr_value), .emr_value(emr_value),
        .cke(b_cke), .cs_n(b_cs_n), .ras_n(b_ras_n), .cas_n(b_cas_n), .we_n(b_we_n),
        .ba(b_ba), .addr(b_addr), .ready(b_ready)
    );

    // 0 NOP, 1 precharge, 2 refresh, 3 mode load, 4 extended load
    function automatic int exp_op(int k, int p, int rp, int rc, int mrd);
        int t_r1, t_r2, t_l, t_e;
        t_r1 = p + rp;
        t_r2 = t_r1 + rc;
        t_l  = t_r2 + rc;
        t_e  = t_l + mrd;
        if (k == p)                return 1;
        if (k == t_r1 || k == t_r2) return 2;
        if (k == t_l)              return 3;
        if (k == t_e)              return 4;
        return 0;
    endfunction

    function automatic logic [19:0] exp_bus(int op, int k, int ready_at);
        logic [3:0]  pins;
        logic [1:0]  ba;
        logic [11:0] addr;
        pins = 4'b0111; ba = 2'b00; addr = 12'h000;
        case (op)
            1: begin pins = 4'b0010; addr = 12'h400; end
            2: pins = 4'b0001;
            3: begin pins = 4'b0000; addr = mr_value & 12'h3FF; end
            4: begin pins = 4'b0000; addr = emr_value & 12'h0FF; ba = 2'b10; end
            default: ;
        endcase
        return {1'b1, pins, ba, addr, (k >= ready_at)};
    endfunction

    function automatic string req_of(int op, int k, int p, int ready_at);
        if (op == 1) return "R3";
        if (op == 2) return "R4";
        if (op == 3) return "R5";
        if (op == 4) return "R6";
        if (k >= ready_at) return "R7";
        if (k < p) return "R2";
        return "R8";
    endfunction

    task automatic check_cycle(string who, string tag, int k, int p, int rp, int rc, int mrd,
                               logic [19:0] act);
        int op, ready_at;
        logic [19:0] expv;
        op       = exp_op(k, p, rp, rc, mrd);
        ready_at = p + rp + 2 * rc + 2 * mrd;
        expv     = exp_bus(op, k, ready_at);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s %s cycle %0d: actual %h expected %h",
                     req_of(op, k, p, ready_at), tag, who, k, act, expv);
        end
    endtask

    task automatic check_reset(string tag);
        logic [19:0] expv;
        expv = {1'b1, 4'b0111, 2'b00, 12'h000, 1'b0};
        n_checks++;
        if ({a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr, a_ready} !== expv) begin
            n_fails++;
            $display("FAIL R1 %s reset A: actual %h expected %h", tag,
                     {a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr, a_ready}, expv);
        end
        n_checks++;
        if ({b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_ba, b_addr, b_ready} !== expv) begin
            n_fails++;
            $display("FAIL R1 %s reset B: actual %h expected %h", tag,
                     {b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_ba, b_addr, b_ready}, expv);
        end
    endtask

    // Called just after a falling edge; abort_k < 0 runs to completion.
    task automatic run_seq(string tag, int rst_len, int abort_k);
        rst = 1'b1;
        repeat (rst_len) @(negedge clk);
        #1;
        check_reset(tag);
        rst = 1'b0;
        for (int k = 0; k <= A_END + 3; k++) begin
            check_cycle("A", tag, k, A_P, A_RP, A_RC, A_MRD,
                        {a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr, a_ready});
            check_cycle("B R10", tag, k, B_P, B_RP, B_RC, B_MRD,
                        {b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_ba, b_addr, b_ready});
            if (k == abort_k) return;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(20 * 5000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D1A_0C7E));
        @(negedge clk);
        #1;

        // Reserved bits all set: R5 and R6 must clear them
        mr_value = 12'hFFF; emr_value = 12'hFFF;
        run_seq("reserved_set", 2, -1);

        mr_value = 12'h000; emr_value = 12'h000;
        run_seq("zero_values", 1, -1);

        for (int i = 0; i < 4; i++) begin
            mr_value  = 12'($urandom);
            emr_value = 12'($urandom);
            run_seq("random", 1 + int'($urandom_range(0, 4)), -1);
        end

        // R9: abort partway, then a full restart must follow from cycle 0
        for (int i = 0; i < 3; i++) begin
            mr_value  = 12'($urandom);
            emr_value = 12'($urandom);
            run_seq("pre_abort", 1, int'($urandom_range(1, A_END - 1)));
            run_seq("R9 restart", 1 + int'($urandom_range(0, 2)), -1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule